// File: doc/BRIEF.md
# Signed Packed-Decimal Register ALU

This block performs add, subtract and compare on signed decimal numbers held in ordinary registers. Each digit is packed in four bits, eight digits to a 32-bit word by default. The leading digit also carries the sign. Codes 0 through 9 in that position give a non-negative number. Codes A through F stand for the two-digit prefixes 94 through 99 of a nine-digit ten's-complement value, so the word is negative. The usable range is therefore lopsided: -60,000,000 up to 99,999,999.

An operation is issued by pulsing `in_valid` together with an operation code and two operands. One clock later `out_valid` pulses and the registered outputs show the outcome:
- an updated result register for add and subtract;
- a three-way code for compare;
- an overflow flag when the true result cannot be encoded;
- a flag for operands that hold a non-decimal lower digit.

Setting the `LONG` parameter widens the words to 64 bits with sixteen digits. The leading-digit rule stays the same, so the long range is -6×10^15 to 10^16-1.

Top module: `pkd_reg_alu`

## Requirements
- R1: A leading digit code of 0 to 9 means a non-negative value. Codes A to F (hex 10 to 15) mean the prefix pair 94 to 99 of a ten's-complement number one digit wider than the word. Hex A0000000 reads as -60,000,000 and hex F9999999 reads as -1.
- R2: With op = 2'b00, `result` becomes the decimal sum a+b, encoded by the R1 rule, provided the operands are valid and the sum is in range.
- R3: With op = 2'b01, `result` becomes the decimal difference a-b, encoded by the R1 rule, provided the operands are valid and the difference is in range.
- R4: If an add or subtract result lies outside -60,000,000..99,999,999, `ovf_flag` is 1 and `result` keeps its previous value. Otherwise `ovf_flag` is 0.
- R5: With op = 2'b10 or 2'b11, `cmp_code` becomes 2'b00 if a = b, 2'b01 if a < b, or 2'b10 if a > b, comparing signed values. `result` is unchanged and `ovf_flag` is 0.
- R6: If any digit below the leading one in either operand exceeds 9, `bad_digit` is 1 and `ovf_flag` is 0, and both `result` and `cmp_code` keep their previous values. Otherwise `bad_digit` is 0.
- R7: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` is high. The two flags change only in that cycle.
- R8: After synchronous reset, `result`, `cmp_code`, `ovf_flag`, `bad_digit` and `out_valid` are all zero.
- R9: With LONG = 1, words are 64 bits of sixteen digits and follow R1 to R6 with range -6,000,000,000,000,000 to 9,999,999,999,999,999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one operation |
| op | input | 2 | 00 add, 01 subtract, 1x compare |
| opnd_a | input | W (32 or 64) | First operand, packed decimal |
| opnd_b | input | W (32 or 64) | Second operand, packed decimal |
| result | output | W (32 or 64) | Result register |
| cmp_code | output | 2 | Compare outcome: 00 equal, 01 less, 10 greater |
| ovf_flag | output | 1 | Last add/subtract was out of range |
| bad_digit | output | 1 | Last operation had a non-decimal lower digit |
| out_valid | output | 1 | Outputs reflect the operation issued one cycle earlier |

## Verification
The operand patterns cover the following cases, and each separates a different fault:
- Sums with no digit carry, a single carry and a ripple through every digit separate a missing decimal correction from a missing carry chain.
- Pairs that cross zero between a negative leading code and a positive word test the A–F prefix mapping in both directions.
- Operands that land exactly on -60,000,000 and 99,999,999, and one step past each, pin the asymmetric range check.
- Compare is run on equal, negative-versus-zero and largest-versus-smallest pairs, and the bench confirms that the result register is left alone.
- A non-decimal lower digit in each operand slot shows that a faulty operation is suppressed.

A sixteen-digit instance repeats the boundary cases at the long width.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_CMP2 = 2'b11
  } pkd_op_e;

  localparam logic [1:0] CMP_EQ = 2'b00;
  localparam logic [1:0] CMP_LT = 2'b01;
  localparam logic [1:0] CMP_GT = 2'b10;

  function automatic logic [3:0] nines(input logic [3:0] d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/pkd_widen.sv
// Expands a packed operand to a ten's-complement value one digit wider (R1)
// and flags non-decimal lower digits (R6).
module pkd_widen #(
  parameter int NDIG = 8
) (
  input  logic [NDIG*4-1:0]     opnd,
  output logic [(NDIG+1)*4-1:0] wide,
  output logic                  bad
);
  localparam int LW = (NDIG-1)*4;

  logic [3:0]      lead;
  logic [7:0]      top_pair;
  logic [NDIG-2:0] dig_bad;

  assign lead = opnd[NDIG*4-1 -: 4];

  genvar i;
  generate
    for (i = 0; i < NDIG-1; i++) begin : g_low
      assign dig_bad[i] = opnd[i*4 +: 4] > 4'd9;
    end
  endgenerate

  always_comb begin
    if (lead <= 4'd9) top_pair = {4'd0, lead};
    else              top_pair = {4'd9, lead - 4'd6};
  end

  assign wide = {top_pair, opnd[LW-1:0]};
  assign bad  = |dig_bad;
endmodule

// File: rtl/pkd_bcd_add.sv
// Ripple decimal adder over ND digits, carry-out discarded (modular).
module pkd_bcd_add #(
  parameter int ND = 9
) (
  input  logic [ND*4-1:0] x,
  input  logic [ND*4-1:0] y,
  input  logic            cin,
  output logic [ND*4-1:0] sum
);
  logic [ND-1:0] c;
  assign c[0] = cin;

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_dig
      logic [4:0] raw;
      logic       adj;
      assign raw = {1'b0, x[i*4 +: 4]} + {1'b0, y[i*4 +: 4]} + {4'd0, c[i]};
      assign adj = raw > 5'd9;
      assign sum[i*4 +: 4] = adj ? raw[3:0] + 4'd6 : raw[3:0];
      if (i < ND-1) begin : g_carry
        assign c[i+1] = adj;
      end
    end
  endgenerate
endmodule

// File: rtl/pkd_fold.sv
// Range check and re-encoding of a widened result back to packed form (R1, R4).
module pkd_fold #(
  parameter int NDIG = 8
) (
  input  logic [(NDIG+1)*4-1:0] wide,
  output logic [NDIG*4-1:0]     packed_out,
  output logic                  in_range,
  output logic                  neg,
  output logic                  zero
);
  localparam int WW = (NDIG+1)*4;
  localparam int LW = (NDIG-1)*4;

  logic [3:0] top_d;
  logic [3:0] next_d;

  assign top_d  = wide[WW-1 -: 4];
  assign next_d = wide[WW-5 -: 4];

  assign in_range   = (top_d == 4'd0) || ((top_d == 4'd9) && (next_d >= 4'd4));
  assign packed_out = {(top_d == 4'd0) ? next_d : next_d + 4'd6, wide[LW-1:0]};
  assign neg        = top_d >= 4'd5;
  assign zero       = (wide == '0);
endmodule

// File: rtl/pkd_reg_alu.sv
module pkd_reg_alu #(
  parameter int LONG = 0,
  localparam int NDIG = (LONG != 0) ? 16 : 8,
  localparam int W    = NDIG*4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic [1:0]   cmp_code,
  output logic         ovf_flag,
  output logic         bad_digit,
  output logic         out_valid
);
  import pkd_pkg::*;

  localparam int ND = NDIG + 1;
  localparam int WW = ND*4;

  logic [WW-1:0] wa, wb, wb_eff, wsum;
  logic          bad_a, bad_b, bad_any;
  logic          do_sub, is_cmp;
  logic [W-1:0]  folded;
  logic          fits, res_neg, res_zero;
  logic [1:0]    cmp_next;

  pkd_widen #(.NDIG(NDIG)) u_wid_a (.opnd(opnd_a), .wide(wa), .bad(bad_a));
  pkd_widen #(.NDIG(NDIG)) u_wid_b (.opnd(opnd_b), .wide(wb), .bad(bad_b));

  assign is_cmp  = op[1];
  assign do_sub  = (op == OP_SUB) || is_cmp;
  assign bad_any = bad_a | bad_b;

  genvar d;
  generate
    for (d = 0; d < ND; d++) begin : g_nines
      assign wb_eff[d*4 +: 4] = do_sub ? nines(wb[d*4 +: 4]) : wb[d*4 +: 4];
    end
  endgenerate

  pkd_bcd_add #(.ND(ND)) u_add (
    .x(wa), .y(wb_eff), .cin(do_sub), .sum(wsum)
  );

  pkd_fold #(.NDIG(NDIG)) u_fold (
    .wide(wsum), .packed_out(folded), .in_range(fits),
    .neg(res_neg), .zero(res_zero)
  );

  always_comb begin
    if (res_zero)     cmp_next = CMP_EQ;
    else if (res_neg) cmp_next = CMP_LT;
    else              cmp_next = CMP_GT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      cmp_code  <= CMP_EQ;
      ovf_flag  <= 1'b0;
      bad_digit <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        bad_digit <= bad_any;
        ovf_flag  <= !bad_any && !is_cmp && !fits;
        if (!bad_any) begin
          if (is_cmp)    cmp_code <= cmp_next;
          else if (fits) result   <= folded;
        end
      end
    end
  end
endmodule

// File: rtl/pkd_reg_alu_chk.sv
module pkd_reg_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   op,
  input logic [W-1:0] result,
  input logic [1:0]   cmp_code,
  input logic         ovf_flag,
  input logic         bad_digit,
  input logic         out_valid
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_flags_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(ovf_flag) && $stable(bad_digit)));

  assert_no_overflow_write_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf_flag) |-> $stable(result));

  assert_bad_suppress_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_digit) |-> ($stable(result) && $stable(cmp_code) && !ovf_flag));

  assert_cmp_keeps_result_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op[1])) |-> ($stable(result) && !ovf_flag));

  assert_cmp_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_code != 2'b11);
endmodule

bind pkd_reg_alu pkd_reg_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .result(result),
  .cmp_code(cmp_code), .ovf_flag(ovf_flag), .bad_digit(bad_digit),
  .out_valid(out_valid)
);

// File: tb/pkd_reg_alu_test.sv
`timescale 1ns/1ps
module pkd_reg_alu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        iv_s = 1'b0, iv_l = 1'b0;
  logic [1:0]  op_s = '0, op_l = '0;
  logic [31:0] a_s = '0, b_s = '0, res_s;
  logic [63:0] a_l = '0, b_l = '0, res_l;
  logic [1:0]  cmp_s, cmp_l;
  logic        ovf_s, ovf_l, bad_s, bad_l, ov_s, ov_l;

  pkd_reg_alu #(.LONG(0)) uut (
    .clk(clk), .rst(rst), .in_valid(iv_s), .op(op_s), .opnd_a(a_s), .opnd_b(b_s),
    .result(res_s), .cmp_code(cmp_s), .ovf_flag(ovf_s), .bad_digit(bad_s),
    .out_valid(ov_s));

  pkd_reg_alu #(.LONG(1)) uut_long (
    .clk(clk), .rst(rst), .in_valid(iv_l), .op(op_l), .opnd_a(a_l), .opnd_b(b_l),
    .result(res_l), .cmp_code(cmp_l), .ovf_flag(ovf_l), .bad_digit(bad_l),
    .out_valid(ov_l));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] er_s = '0, er_l = '0;
  logic [1:0]  ec_s = '0, ec_l = '0;
  logic        eo_s = 0, eo_l = 0, eb_s = 0, eb_l = 0;

  function automatic longint p10(int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic longint dec(logic [63:0] v, int nd);
    longint low = 0;
    longint lead = longint'(v[(nd-1)*4 +: 4]);
    for (int i = nd-2; i >= 0; i--) low = low*10 + longint'(v[i*4 +: 4]);
    if (lead <= 9) return lead*p10(nd-1) + low;
    return (lead+84)*p10(nd-1) + low - p10(nd+1);
  endfunction

  function automatic logic [63:0] enc(longint x, int nd);
    logic [63:0] o = '0;
    longint r = (x < 0) ? x + p10(nd+1) : x;
    longint lead;
    for (int i = 0; i < nd-1; i++) begin
      o[i*4 +: 4] = 4'(r % 10);
      r = r / 10;
    end
    lead = (r >= 94) ? r - 84 : r;
    o[(nd-1)*4 +: 4] = 4'(lead);
    return o;
  endfunction

  function automatic bit has_bad(logic [63:0] v, int nd);
    for (int i = 0; i < nd-1; i++) if (v[i*4 +: 4] > 4'd9) return 1;
    return 0;
  endfunction

  task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation, predict every output, sample one cycle later.
  task automatic apply(bit lng, logic [1:0] o, logic [63:0] a, logic [63:0] b, string tag_in);
    int nd = lng ? 16 : 8;
    bit bd = has_bad(a, nd) || has_bad(b, nd);
    longint va = dec(a, nd), vb = dec(b, nd);
    longint r = (o == 2'b00) ? va + vb : va - vb;
    bit inr = (r >= -6*p10(nd-1)) && (r <= p10(nd) - 1);
    logic [63:0] er = lng ? er_l : er_s;
    logic [1:0]  ec = lng ? ec_l : ec_s;
    bit eo = !bd && !o[1] && !inr;
    string tag;
    logic [68:0] act, exp;
    if (!bd) begin
      if (o[1]) ec = (r == 0) ? 2'b00 : (r < 0) ? 2'b01 : 2'b10;
      else if (inr) er = enc(r, nd);
    end
    if (tag_in != "") tag = tag_in;
    else if (bd) tag = "R6";
    else if (o[1]) tag = "R5";
    else if (eo) tag = "R4";
    else if (o == 2'b01) tag = "R3";
    else tag = "R2";
    @(negedge clk);
    if (lng) begin iv_l = 1; op_l = o; a_l = a; b_l = b; end
    else begin iv_s = 1; op_s = o; a_s = a[31:0]; b_s = b[31:0]; end
    @(negedge clk);
    iv_s = 0; iv_l = 0;
    if (lng) begin er_l = er; ec_l = ec; eo_l = eo; eb_l = bd; end
    else     begin er_s = er; ec_s = ec; eo_s = eo; eb_s = bd; end
    exp = {er, ec, eo, bd, 1'b1};
    act = lng ? {res_l, cmp_l, ovf_l, bad_l, ov_l}
              : {32'h0, res_s, cmp_s, ovf_s, bad_s, ov_s};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%b a=%h b=%h actual=%h expected=%h", tag, o, a, b, act, exp);
    end
  endtask

  localparam int NV = 16;
  localparam logic [65:0] VEC [NV] = '{
    {2'b00, 32'h00000012, 32'h00000030},   // plain add
    {2'b00, 32'h12345678, 32'h11111111},   // no carries
    {2'b00, 32'h00000009, 32'h00000001},   // single decimal carry
    {2'b00, 32'h49999999, 32'h00000001},   // ripple through all digits
    {2'b00, 32'hB1234567, 32'h05000000},   // negative plus positive
    {2'b00, 32'h99999999, 32'h00000001},   // above max -> R4
    {2'b00, 32'hA0000000, 32'hF9999999},   // below min -> R4
    {2'b01, 32'h00000005, 32'h00000007},   // goes negative
    {2'b01, 32'h00000000, 32'h60000000},   // lands on minimum
    {2'b01, 32'h00000000, 32'h60000001},   // one past minimum -> R4
    {2'b01, 32'h50000000, 32'hA0000000},   // large positive -> R4
    {2'b10, 32'h00001234, 32'h00001234},   // equal
    {2'b10, 32'hF9999999, 32'h00000000},   // less
    {2'b11, 32'h99999999, 32'hA0000000},   // greater, alternate code
    {2'b00, 32'h0000000A, 32'h00000000},   // bad digit in a -> R6
    {2'b10, 32'h00000001, 32'h000B0000}    // bad digit in b on compare -> R6
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8: reset state
    check_val("R8", {res_s, cmp_s, ovf_s, bad_s, ov_s}, 64'h0);
    check_val("R8", {res_l[59:0], cmp_l, ovf_l, bad_l, ov_l}, 64'h0);

    for (int k = 0; k < NV; k++)
      apply(0, VEC[k][65:64], {32'h0, VEC[k][63:32]}, {32'h0, VEC[k][31:0]}, "");

    // R1: leading-code decoding at the extremes
    apply(0, 2'b00, 64'hA0000000, 64'h0, "R1");
    check_val("R1", {32'h0, res_s}, 64'hA0000000);
    apply(0, 2'b00, 64'hF9999999, 64'h1, "R1");
    check_val("R1", {32'h0, res_s}, 64'h0);
    apply(0, 2'b10, 64'hA0000000, 64'hF9999999, "R1");
    check_val("R1", {62'h0, cmp_s}, 64'h1);

    // R7: idle cycle after a result, nothing moves
    apply(0, 2'b00, 64'h99999999, 64'h99999999, "R4");
    @(negedge clk);
    check_val("R7", {res_s, cmp_s, ovf_s, bad_s, ov_s},
              {er_s[31:0], ec_s, eo_s, eb_s, 1'b0});

    // R9: sixteen-digit variant
    apply(1, 2'b00, 64'h1234567890123456, 64'h1111111111111111, "R9");
    apply(1, 2'b00, 64'hA000000000000000, 64'h0, "R9");
    check_val("R9", res_l, 64'hA000000000000000);
    apply(1, 2'b00, 64'h9999999999999999, 64'h1, "R9");
    apply(1, 2'b01, 64'h0, 64'h1, "R9");
    check_val("R9", res_l, 64'hF999999999999999);
    apply(1, 2'b10, 64'h9999999999999999, 64'hA000000000000000, "R9");
    apply(1, 2'b00, 64'h00000000000000C0, 64'h0, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule